// File: doc/BRIEF.md
# Prescaled Compare-Match Interval Timer

This block is a memory-mapped timer with a fixed-width up-counter, a threshold register and a small control word. Software picks a clock division from an eight-step ladder and enables the timer. The counter then advances by one on every divided tick. When the counter equals the threshold on a tick, the block emits a one-cycle interrupt pulse and sets a sticky pending flag. After that it either freezes (single-shot) or wraps back to zero and keeps counting (continuous).

Software reaches the block through a plain synchronous register port. Writes are taken on the rising clock edge when the write strobe is high. Reads are combinational from the current address. The port has no handshake and no stream interface: every access completes in the cycle it is presented. A local clear input models the acknowledge that an interrupt controller would otherwise provide.

Top module: `ivt_timer`

## Requirements
- R1: Byte address 0x0 selects the control word, 0x4 the threshold and 0x8 the count. All three can be written and read back. Address 0xC, and any address whose two low bits are not zero, reads as zero and ignores writes.
- R2: In the control word, bit 0 enables the timer, bits 3:1 hold the division code and bit 4 selects the mode (1 = continuous, 0 = single-shot). Bits 31:5 always read as zero.
- R3: Division codes 0 through 7 give tick periods of 2, 4, 8, 64, 128, 1024, 2048 and 4096 clocks. With a period of N, the first increment lands N/2+1 edges after the edge that writes the enable, and every later increment follows N edges after the one before.
- R4: While the enable is clear the count holds its value, and clearing the enable does not alter it. Re-enabling restarts the divider, so the first increment after re-enabling again lands N/2+1 edges later.
- R5: On a tick where count equals threshold, the interrupt pulse is high for exactly the one cycle after that edge. On any other tick, the count rises by one.
- R6: In single-shot mode the count freezes at the threshold after the matching tick, and no further pulses occur. Writing the count or the threshold restarts counting.
- R7: In continuous mode the count becomes zero on the matching tick. The count after k ticks is therefore k mod (threshold+1).
- R8: A software write to the count takes priority over an increment or a reload on the same edge.
- R9: The pending output goes high with each pulse and stays high until the clear input is sampled high. If a new pulse and a clear arrive on the same edge, the pulse wins.
- R10: After reset, all registers read zero, and both the pulse and pending outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 4 | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_pulse_o | output | 1 | One-cycle pulse on each match event |
| irq_pending_o | output | 1 | Sticky pending flag |
| irq_clr_i | input | 1 | Clears the pending flag |

## Verification
Several assertions assume that nothing but a tick or a software write moves the count. Their antecedents therefore exclude cycles where the count is written. The bench issues writes only through a task that holds the strobe for exactly one edge, so every other edge is a pure timer edge. The sweeps run with the threshold written before enabling, and they sample between edges. This keeps each expected count and pulse a closed-form function of the number of edges since the enable write.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DIV_W  = 12;
  localparam int unsigned TAP_W  = $clog2(DIV_W);
  localparam int unsigned CTRL_W = 5;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_THR  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  typedef struct packed {
    logic       cont;
    logic [2:0] code;
    logic       en;
  } ctrl_t;

  // Divider bit whose rising edge marks one tick for each division code.
  function automatic logic [TAP_W-1:0] tap_of(input logic [2:0] code);
    case (code)
      3'd0:    tap_of = TAP_W'(0);
      3'd1:    tap_of = TAP_W'(1);
      3'd2:    tap_of = TAP_W'(2);
      3'd3:    tap_of = TAP_W'(5);
      3'd4:    tap_of = TAP_W'(6);
      3'd5:    tap_of = TAP_W'(9);
      3'd6:    tap_of = TAP_W'(10);
      default: tap_of = TAP_W'(11);
    endcase
  endfunction
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
  import ivt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] code_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;
  logic             prev_q;
  logic             tap;

  always_comb tap = div_q[tap_of(code_i)];

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      div_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      div_q  <= div_q + DIV_W'(1);
      prev_q <= tap;
    end
  end

  assign tick_o = en_i & tap & ~prev_q;

  // R3: ticks are never on adjacent cycles (shortest period is two)
  a_r3_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         cont_i,
  input  logic         tick_i,
  input  logic         cnt_we_i,
  input  logic         thr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] thr_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, thr_q;
  logic         halted_q;
  logic         live, hit;

  assign live = tick_i & en_i & ~halted_q;
  assign hit  = live & (cnt_q == thr_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      thr_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (thr_we_i) thr_q <= wdata_i;
      if (cnt_we_i)           cnt_q <= wdata_i;
      else if (hit && cont_i) cnt_q <= '0;
      else if (live && !hit)  cnt_q <= cnt_q + W'(1);
      if (cnt_we_i || thr_we_i) halted_q <= 1'b0;
      else if (hit && !cont_i)  halted_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign thr_o = thr_q;
  assign hit_o = hit;

  // R4: a disabled timer keeps its count
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_we_i) |=> $stable(cnt_q));
  // R5: without a tick the count only moves by software write
  a_r5_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_we_i) |=> $stable(cnt_q));
  // R6: single-shot match freezes the count until software acts
  a_r6_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !cont_i && !cnt_we_i && !thr_we_i) |=> (cnt_q == $past(cnt_q)) && !hit);
  // R7: continuous match reloads zero
  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cont_i && !cnt_we_i) |=> (cnt_q == '0));
  // R8: software write wins
  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_pulse_o,
  output logic              irq_pending_o,
  input  logic              irq_clr_i
);
  ctrl_t             ctrl_q;
  logic              aligned;
  logic [1:0]        wsel;
  logic              tick, hit;
  logic              pulse_q, pend_q;
  logic [DATA_W-1:0] cnt, thr;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wsel    = addr_i[3:2];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && aligned && wsel == SEL_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  ivt_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.en),
    .code_i (ctrl_q.code),
    .tick_o (tick)
  );

  ivt_counter #(.W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl_q.en),
    .cont_i   (ctrl_q.cont),
    .tick_i   (tick),
    .cnt_we_i (we_i && aligned && wsel == SEL_CNT),
    .thr_we_i (we_i && aligned && wsel == SEL_THR),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt),
    .thr_o    (thr),
    .hit_o    (hit)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      pulse_q <= hit;
      pend_q  <= (pend_q & ~irq_clr_i) | hit;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (wsel)
        SEL_CTRL: rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        SEL_THR:  rdata_o = thr;
        SEL_CNT:  rdata_o = cnt;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_pulse_o   = pulse_q;
  assign irq_pending_o = pend_q;

  // R5: each match gives a single-cycle pulse
  a_r5_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |=> !irq_pulse_o);
  // R9: pending persists without a clear, and follows every pulse
  a_r9_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pending_o && !irq_clr_i) |=> irq_pending_o);
  a_r9_pend_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> irq_pending_o);
  // R2: upper control bits read zero
  a_r2_ctrl_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 4'h0) |-> (rdata_o[DATA_W-1:CTRL_W] == '0));
  // R1: unmapped slot reads zero
  a_r1_hole_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsel == 2'd3) |-> (rdata_o == '0));
endmodule

// File: tb/tb_ivt_timer.sv
`timescale 1ns/1ps
module tb_ivt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pulse, pend;
  logic        clr = 1'b0;
  int          checks = 0;
  int          fails = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_THR = 4'h4, A_CNT = 4'h8;

  always #2 clk = ~clk;

  ivt_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_pulse_o(pulse), .irq_pending_o(pend), .irq_clr_i(clr)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic clear_pend();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  function automatic int period_of(input int c);
    if (c < 3)      return 2 << c;
    else if (c < 5) return 8 << c;
    else            return 32 << c;
  endfunction

  task automatic cont_sweep(input int t_thr, input logic hold_clr);
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_THR, t_thr); clear_pend();
    clr = hold_clr;
    wr(A_CTRL, 32'h11);
    for (int t = 1; t <= 6 * (t_thr + 1) + 4; t++) begin
      int k;
      logic ep;
      @(negedge clk);
      k = t / 2;
      ep = (t % 2 == 0) && (k >= 1) && (k % (t_thr + 1) == 0);
      rd(A_CNT, v);
      chk($sformatf("R7 cont thr=%0d t=%0d count", t_thr, t), v, k % (t_thr + 1));
      chk($sformatf("R5 cont thr=%0d t=%0d pulse", t_thr, t), {31'd0, pulse}, {31'd0, ep});
      if (hold_clr) chk($sformatf("R9 set-over-clear t=%0d", t), {31'd0, pend}, {31'd0, ep});
    end
    clr = 1'b0;
    wr(A_CTRL, 0);
  endtask

  task automatic single_sweep(input int t_thr);
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_THR, t_thr); clear_pend();
    wr(A_CTRL, 32'h01);
    for (int t = 1; t <= 2 * t_thr + 8; t++) begin
      int k;
      logic ep;
      @(negedge clk);
      k = t / 2;
      ep = (t % 2 == 0) && (k == t_thr + 1);
      rd(A_CNT, v);
      chk($sformatf("R6 single thr=%0d t=%0d count", t_thr, t), v, (k < t_thr) ? k : t_thr);
      chk($sformatf("R5 single thr=%0d t=%0d pulse", t_thr, t), {31'd0, pulse}, {31'd0, ep});
    end
    repeat (5) @(negedge clk);
    chk("R9 pending held", {31'd0, pend}, 32'd1);
    clear_pend();
    chk("R9 pending cleared", {31'd0, pend}, 32'd0);
    wr(A_CNT, 0);
    repeat (2 * t_thr + 8) @(negedge clk);
    rd(A_CNT, v);
    chk("R6 resume after count write", v, t_thr);
    chk("R6 resume raises pending", {31'd0, pend}, 32'd1);
    wr(A_CTRL, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    rd(A_CTRL, v); chk("R10 ctrl reset", v, 0);
    rd(A_THR, v);  chk("R10 thr reset", v, 0);
    rd(A_CNT, v);  chk("R10 cnt reset", v, 0);
    chk("R10 pulse reset", {31'd0, pulse}, 0);
    chk("R10 pending reset", {31'd0, pend}, 0);

    // R1: register map and holes
    wr(A_THR, 32'hA5A5_1234); wr(A_CNT, 32'h0F0F_7777);
    rd(A_THR, v); chk("R1 thr readback", v, 32'hA5A5_1234);
    rd(A_CNT, v); chk("R1 cnt readback", v, 32'h0F0F_7777);
    wr(4'hC, 32'hFFFF_FFFF); wr(4'h5, 32'h1);
    rd(4'hC, v); chk("R1 hole reads zero", v, 0);
    rd(4'h5, v); chk("R1 misaligned reads zero", v, 0);
    rd(A_THR, v); chk("R1 thr untouched by hole write", v, 32'hA5A5_1234);
    rd(A_CNT, v); chk("R1 cnt untouched by hole write", v, 32'h0F0F_7777);
    rd(A_CTRL, v); chk("R1 ctrl untouched by hole write", v, 0);

    // R2: control fields
    wr(A_CTRL, 32'hFFFF_FFE6);
    rd(A_CTRL, v); chk("R2 ctrl fields", v, 32'h06);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 upper bits zero", v, 32'h1F);
    wr(A_CTRL, 0);

    // R3: prescaler ladder sweep
    for (int c = 0; c < 8; c++) begin
      int n;
      n = period_of(c);
      wr(A_CNT, 0); wr(A_THR, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h11 | (c << 1));
      repeat (n / 2) @(negedge clk);
      rd(A_CNT, v); chk($sformatf("R3 code %0d before first tick", c), v, 0);
      @(negedge clk);
      rd(A_CNT, v); chk($sformatf("R3 code %0d first tick", c), v, 1);
      repeat (n - 1) @(negedge clk);
      rd(A_CNT, v); chk($sformatf("R3 code %0d before second tick", c), v, 1);
      @(negedge clk);
      rd(A_CNT, v); chk($sformatf("R3 code %0d second tick", c), v, 2);
      wr(A_CTRL, 0);
    end

    // R4: disable holds, re-enable restarts divider (period 4)
    wr(A_CNT, 0); wr(A_THR, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h13);
    repeat (7) @(negedge clk);
    rd(A_CNT, v); chk("R4 running count", v, 2);
    wr(A_CTRL, 32'h12);
    repeat (20) @(negedge clk);
    rd(A_CNT, v); chk("R4 count held while disabled", v, 2);
    wr(A_CTRL, 32'h13);
    repeat (2) @(negedge clk);
    rd(A_CNT, v); chk("R4 no early tick after re-enable", v, 2);
    @(negedge clk);
    rd(A_CNT, v); chk("R4 first tick after re-enable", v, 3);
    wr(A_CTRL, 0);

    // R8: count write on a tick edge wins
    wr(A_CNT, 0); wr(A_THR, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h11);
    wr(A_CNT, 32'd100);
    rd(A_CNT, v); chk("R8 write beats increment", v, 100);
    @(negedge clk); @(negedge clk);
    rd(A_CNT, v); chk("R8 increments after write", v, 101);
    wr(A_CTRL, 0);

    // R5, R7, R9: continuous sweeps
    for (int t = 0; t < 5; t++) cont_sweep(t, 1'b0);
    cont_sweep(0, 1'b1);
    cont_sweep(2, 1'b1);
    // R5, R6, R9: single-shot sweeps
    for (int t = 0; t < 5; t++) single_sweep(t);

    finish_run();
  end
endmodule